// File: doc/BRIEF.md
# Cascadable Configuration-Stream ROM Read Port

This block is the read side of a configuration memory that feeds a programmable device as it boots. An external configuration clock steps an internal read pointer through a fixed ROM image. The image leaves the block either as one bit per clock on lane 0 or as one whole byte per clock on all eight lanes. A static mode input selects the format. A low level on the mode input selects the bit-serial format, and that is the default strapping.

Two control inputs gate the pointer. An active-low output-enable/reset input and an active-low chip enable must both be asserted for the pointer to move. Releasing either one returns the port to address zero and floats every data lane. Several ports can share one clock and one data bus in a daisy chain. The chain-enable output of one port drives the chip enable of the next. When a port has delivered its last byte, the next clock edge floats its lanes and drives its chain-enable output low, and the following port takes the bus over without losing a clock.

Top module: `cfgrom_port`

## Requirements
- R1: Each rising clock edge at which `oe_rst_n` is 1 and `ce_n` is 0 moves the output to the next element of the image, unless the image is already used up. In byte mode the next element is the next address. In serial mode it is the next bit.
- R2: At a clock edge with `oe_rst_n` at 0, the pointer goes to address 0, bit 7. While `oe_rst_n` is 0, `data_oe` is 8'h00 and `ceo_n` is 1, both without waiting for a clock edge.
- R3: At a clock edge with `ce_n` at 1, the pointer goes to address 0, bit 7. While `ce_n` is 1, `data_oe` is 8'h00 and `ceo_n` is 1.
- R4: In byte mode (`par_mode`=1), an active port drives `data_oe`=8'hFF and `data_o` = the image byte at the current address. The image byte at address a is the low 8 bits of a*29 + SEED.
- R5: In serial mode (`par_mode`=0), an active port drives `data_oe`=8'h01. `data_o[0]` carries bit 7 of the current byte first and bit 0 last, and the address moves on after bit 0.
- R6: `par_mode`=0 selects serial output, with lanes 7..1 floated. `par_mode`=1 selects byte output.
- R7: Terminal count is address DEPTH-1. The enabled edge that consumes the last element (byte DEPTH-1, or bit 0 of that byte) floats `data_oe` to 8'h00 and drives `ceo_n` to 0. Later enabled edges leave that state unchanged.
- R8: `ceo_n` returns to 1 as soon as `oe_rst_n` goes to 0 or `ce_n` goes to 1, without waiting for a clock edge.
- R9: With two ports chained (`ceo_n` of the first to `ce_n` of the second, clock and bus shared), the bus carries the first image and then the second image, one element per clock. No lane is driven by both ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; state changes on its rising edge |
| oe_rst_n | input | 1 | Active-low output enable and pointer reset, synchronous for the pointer |
| ce_n | input | 1 | Active-low chip enable; high means standby and pointer reset |
| par_mode | input | 1 | Output format: 0 bit-serial on lane 0, 1 byte-wide |
| data_o | output | 8 | Data lanes, meaningful where `data_oe` is set |
| data_oe | output | 8 | Per-lane drive enable; a clear bit means that lane is floated |
| ceo_n | output | 1 | Active-low chain enable for the next port |

## Verification
Two functions can meet in one cycle. One is the terminal-count handoff, which floats this port and enables the next. The other is the release of a control input, which must pull `ceo_n` back high at once and reset both ports at the following edge. Directed cases raise the first port's chip enable and drop the shared reset in the middle of a cycle, right after the handoff, while the second port is mid-stream. Random stimulus also pulses both controls at arbitrary points across repeated chain runs. Every cycle a bench model of both ports predicts each lane, each enable and each chain output, and the bench also checks that the two ports never drive the shared bus in the same cycle.

// File: rtl/cfgrom_pkg.sv
// Shared types and the computed ROM image for the configuration read port.
// Assumes byte-wide storage. The image is generated from the address and a seed,
// so no table is stored.
package cfgrom_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        FMT_SERIAL = 1'b0,
        FMT_BYTE   = 1'b1
    } out_fmt_e;

    // Image byte at address a: low byte of a*29 + seed
    function automatic byte_t image_byte(input logic [31:0] a, input byte_t seed);
        logic [31:0] t;
        t = a * 32'd29 + {24'd0, seed};
        return t[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/cfgrom_addr_ctr.sv
// Read pointer: byte address, bit index within the byte, and a used-up flag.
// Assumes par_mode changes only while the port is held in reset or standby.
// The pointer saturates at DEPTH-1 and the used-up flag holds until reset.
module cfgrom_addr_ctr
    import cfgrom_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             oe_rst_n,
    input  logic             ce_n,
    input  logic             par_mode,
    output logic [AW-1:0]    addr_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             done_o
);
    localparam logic [AW-1:0]    LAST    = AW'(DEPTH - 1);
    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BYTE_W - 1);

    logic [AW-1:0]    addr_q;
    logic [BIT_W-1:0] bit_q;
    logic             done_q;
    logic             step_en;
    logic             byte_end;
    out_fmt_e         fmt;

    // Decode the output format and whether this edge finishes a byte
    always_comb begin
        fmt      = out_fmt_e'(par_mode);
        step_en  = oe_rst_n && !ce_n && !done_q;
        byte_end = (fmt == FMT_BYTE) || (bit_q == '0);
    end

    // Pointer update: reset or standby clears it, otherwise step and saturate
    always_ff @(posedge clk) begin
        if (!oe_rst_n || ce_n) begin
            addr_q <= '0;
            bit_q  <= BIT_TOP;
            done_q <= 1'b0;
        end else if (step_en) begin
            if (byte_end) begin
                bit_q <= BIT_TOP;
                if (addr_q == LAST) begin
                    done_q <= 1'b1;
                end else begin
                    addr_q <= addr_q + AW'(1);
                end
            end else begin
                bit_q <= bit_q - BIT_W'(1);
            end
        end
    end

    assign addr_o = addr_q;
    assign bit_o  = bit_q;
    assign done_o = done_q;

    p_reset_clears_r2: assert property (@(posedge clk)
        !oe_rst_n |=> (addr_q == '0 && bit_q == BIT_TOP && !done_q));

    p_standby_clears_r3: assert property (@(posedge clk)
        ce_n |=> (addr_q == '0 && bit_q == BIT_TOP && !done_q));

    p_advance_r1: assert property (@(posedge clk)
        (oe_rst_n && !ce_n && !done_q && par_mode && addr_q != LAST)
        |=> (addr_q == $past(addr_q) + AW'(1)));

    p_msb_first_r5: assert property (@(posedge clk)
        (oe_rst_n && !ce_n && !done_q && !par_mode && bit_q != '0)
        |=> (bit_q == $past(bit_q) - BIT_W'(1) && addr_q == $past(addr_q)));

    p_saturate_r7: assert property (@(posedge clk)
        (done_q && oe_rst_n && !ce_n) |=> (done_q && addr_q == LAST));
endmodule

// File: rtl/cfgrom_array.sv
// Read-only image. It returns the stored byte for an address in the same cycle.
// Assumes the contents are fixed at elaboration by SEED.
module cfgrom_array
    import cfgrom_pkg::*;
#(
    parameter int          DEPTH = 16,
    parameter logic [7:0]  SEED  = 8'h5A,
    localparam int         AW    = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] addr_i,
    output byte_t         byte_o
);
    // Look up the generated image byte for the current address
    always_comb begin
        byte_o = image_byte(32'(addr_i), SEED);
    end
endmodule

// File: rtl/cfgrom_outdrv.sv
// Lane driver and chain-enable output. It floats every lane when reset, standby
// or the used-up flag applies. In serial format only lane 0 carries data.
// The clock is used only by the assertions.
module cfgrom_outdrv
    import cfgrom_pkg::*;
(
    input  logic             clk,
    input  logic             oe_rst_n,
    input  logic             ce_n,
    input  logic             par_mode,
    input  logic             done_i,
    input  byte_t            byte_i,
    input  logic [BIT_W-1:0] bit_i,
    output byte_t            data_o,
    output byte_t            data_oe,
    output logic             ceo_n
);
    logic active;
    logic serial_bit;

    // Decide whether this port owns the bus and pick the serial bit
    always_comb begin
        active     = oe_rst_n && !ce_n && !done_i;
        serial_bit = byte_i[bit_i];
        ceo_n      = !(done_i && oe_rst_n && !ce_n);
    end

    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        if (g == 0) begin : g_lane0
            // Lane 0 carries data in both formats
            always_comb begin
                data_oe[g] = active;
                data_o[g]  = active && (par_mode ? byte_i[g] : serial_bit);
            end
        end else begin : g_upper
            // Upper lanes carry data in byte format only
            always_comb begin
                data_oe[g] = active && par_mode;
                data_o[g]  = active && par_mode && byte_i[g];
            end
        end
    end

    p_upper_float_serial_r5: assert property (@(posedge clk)
        !par_mode |-> (data_oe[BYTE_W-1:1] == '0));

    p_ceo_release_r8: assert property (@(posedge clk)
        (!oe_rst_n || ce_n) |-> ceo_n);

    p_handoff_float_r7: assert property (@(posedge clk)
        !ceo_n |-> (data_oe == '0));
endmodule

// File: rtl/cfgrom_port.sv
// Top level of the cascadable configuration-stream read port.
// It connects the read pointer, the image and the lane driver.
// Assumes par_mode is changed only while oe_rst_n is low or ce_n is high.
module cfgrom_port
    import cfgrom_pkg::*;
#(
    parameter int         DEPTH = 16,
    parameter logic [7:0] SEED  = 8'h5A
) (
    input  logic       clk,
    input  logic       oe_rst_n,
    input  logic       ce_n,
    input  logic       par_mode,
    output logic [7:0] data_o,
    output logic [7:0] data_oe,
    output logic       ceo_n
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]    addr;
    logic [BIT_W-1:0] bit_idx;
    logic             used_up;
    byte_t            cur_byte;

    cfgrom_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk      (clk),
        .oe_rst_n (oe_rst_n),
        .ce_n     (ce_n),
        .par_mode (par_mode),
        .addr_o   (addr),
        .bit_o    (bit_idx),
        .done_o   (used_up)
    );

    cfgrom_array #(.DEPTH(DEPTH), .SEED(SEED)) u_img (
        .addr_i (addr),
        .byte_o (cur_byte)
    );

    cfgrom_outdrv u_drv (
        .clk      (clk),
        .oe_rst_n (oe_rst_n),
        .ce_n     (ce_n),
        .par_mode (par_mode),
        .done_i   (used_up),
        .byte_i   (cur_byte),
        .bit_i    (bit_idx),
        .data_o   (data_o),
        .data_oe  (data_oe),
        .ceo_n    (ceo_n)
    );
endmodule

// File: tb/cfgrom_port_test.sv
`timescale 1ns/1ps
module cfgrom_port_test;
    localparam int         DEPTH  = 16;
    localparam logic [7:0] SEED_A = 8'h5A;
    localparam logic [7:0] SEED_B = 8'hC3;

    logic clk = 1'b0;
    logic oe_rst_n = 1'b0;
    logic ce_a_n = 1'b0;
    logic par_mode = 1'b1;
    logic [7:0] a_d, a_oe, b_d, b_oe;
    logic a_ceo, b_ceo;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int m_addr [2];
    int m_bit  [2];
    bit m_done [2];

    always #2.5 clk = ~clk;

    cfgrom_port #(.DEPTH(DEPTH), .SEED(SEED_A)) uut (
        .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ce_a_n), .par_mode(par_mode),
        .data_o(a_d), .data_oe(a_oe), .ceo_n(a_ceo));

    cfgrom_port #(.DEPTH(DEPTH), .SEED(SEED_B)) dev_b (
        .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(a_ceo), .par_mode(par_mode),
        .data_o(b_d), .data_oe(b_oe), .ceo_n(b_ceo));

    function automatic logic [7:0] content(input logic [7:0] seed, input int a);
        int t;
        t = a * 29 + int'(seed);
        return t[7:0];
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected chain output of device k under the current inputs
    function automatic bit exp_ceo(input int k, input logic ce);
        return !(m_done[k] && oe_rst_n && !ce);
    endfunction

    function automatic void exp_out(input int k, input logic ce,
                                    output logic [7:0] d, output logic [7:0] oe);
        logic [7:0] byt;
        byt = content(k == 0 ? SEED_A : SEED_B, m_addr[k]);
        d = 8'h00; oe = 8'h00;
        if (oe_rst_n && !ce && !m_done[k]) begin
            if (par_mode) begin oe = 8'hFF; d = byt; end
            else begin oe = 8'h01; d = {7'd0, byt[m_bit[k]]}; end
        end
    endfunction

    task automatic upd(input int k, input logic rst, input logic ce);
        if (!rst || ce) begin
            m_addr[k] = 0; m_bit[k] = 7; m_done[k] = 0;
        end else if (!m_done[k]) begin
            if (par_mode || m_bit[k] == 0) begin
                m_bit[k] = 7;
                if (m_addr[k] == DEPTH - 1) m_done[k] = 1;
                else m_addr[k]++;
            end else m_bit[k]--;
        end
    endtask

    // One clock: update the model with the inputs seen at the edge, return at the falling edge
    task automatic tick();
        logic ce_b;
        ce_b = exp_ceo(0, ce_a_n);
        @(posedge clk);
        upd(0, oe_rst_n, ce_a_n);
        upd(1, oe_rst_n, ce_b);
        @(negedge clk);
    endtask

    function automatic string tag_of(input int k, input logic ce);
        if (!oe_rst_n) return "R2";
        if (ce) return "R3";
        if (m_done[k]) return "R7";
        return par_mode ? "R4" : "R5";
    endfunction

    // Compare both ports and the shared bus against the model
    task automatic check_all();
        logic [7:0] ed, eo;
        logic ce_b;
        #1;
        ce_b = exp_ceo(0, ce_a_n);
        exp_out(0, ce_a_n, ed, eo);
        chk({a_oe, a_d & a_oe, a_ceo} == {eo, ed, ce_b}, tag_of(0, ce_a_n),
            {a_oe, a_d & a_oe}, {eo, ed});
        chk(a_ceo == ce_b, "R8 ceo A", {15'd0, a_ceo}, {15'd0, ce_b});
        exp_out(1, ce_b, ed, eo);
        chk({b_oe, b_d & b_oe} == {eo, ed}, tag_of(1, ce_b), {b_oe, b_d & b_oe}, {eo, ed});
        chk((a_oe & b_oe) == 8'h00, "R9 bus overlap", {a_oe, b_oe}, 16'h0000);
    endtask

    function automatic logic [7:0] bus();
        return (a_d & a_oe) | (b_d & b_oe);
    endfunction

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2; k++) begin m_addr[k] = 0; m_bit[k] = 7; m_done[k] = 0; end

        // Reset state (R2)
        tick(); tick();
        check_all();
        chk(a_oe == 8'h00 && a_ceo == 1'b1, "R2 reset state", {a_oe, 7'd0, a_ceo}, 16'h0001);

        // Byte-wide chain run (R1, R4, R7, R9)
        oe_rst_n = 1'b1;
        for (int i = 0; i < 2 * DEPTH + 3; i++) begin
            check_all();
            b = (i < DEPTH) ? content(SEED_A, i) :
                (i < 2 * DEPTH) ? content(SEED_B, i - DEPTH) : 8'h00;
            chk(bus() == b, "R9 chained stream", {8'd0, bus()}, {8'd0, b});
            if (i < DEPTH) chk(a_d == b, "R1 one byte per edge", {8'd0, a_d}, {8'd0, b});
            if (i == DEPTH)
                chk(a_oe == 8'h00 && a_ceo == 1'b0, "R7 handoff", {a_oe, 7'd0, a_ceo}, 16'h0000);
            if (i == 2 * DEPTH + 2)
                chk(a_oe == 8'h00 && a_ceo == 1'b0, "R7 saturate", {a_oe, 7'd0, a_ceo}, 16'h0000);
            tick();
        end

        // Mid-cycle release of chip enable after handoff (R8, R3)
        ce_a_n = 1'b1;
        check_all();
        chk(a_ceo == 1'b1, "R8 ceo on ce release", {15'd0, a_ceo}, 16'h0001);
        tick(); check_all();
        ce_a_n = 1'b0;
        check_all();
        chk(a_d == content(SEED_A, 0), "R3 restart at 0", {8'd0, a_d}, {8'd0, content(SEED_A, 0)});

        // Mid-cycle reset after handoff (R8)
        for (int i = 0; i < DEPTH; i++) tick();
        check_all();
        oe_rst_n = 1'b0;
        check_all();
        chk(a_ceo == 1'b1 && a_oe == 8'h00, "R8 ceo on reset", {a_oe, 7'd0, a_ceo}, 16'h0001);

        // Serial format, MSB first (R5, R6)
        par_mode = 1'b0;
        tick();
        oe_rst_n = 1'b1;
        check_all();
        chk(a_oe == 8'h01, "R6 serial lanes", {8'd0, a_oe}, 16'h0001);
        for (int i = 0; i < 16; i++) begin
            b = content(SEED_A, i / 8);
            check_all();
            chk(a_d[0] == b[7 - (i % 8)], "R5 serial bit order", {15'd0, a_d[0]}, {15'd0, b[7 - (i % 8)]});
            tick();
        end

        // Random phase: control pulses at arbitrary points
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 99) < 2) begin
                oe_rst_n = 1'b0;
                if ($urandom_range(0, 1) == 1) par_mode = ~par_mode;
            end else if (!oe_rst_n && $urandom_range(0, 3) == 0) begin
                oe_rst_n = 1'b1;
            end
            if ($urandom_range(0, 99) < 2) ce_a_n = ~ce_a_n;
            else if (ce_a_n && $urandom_range(0, 3) == 0) ce_a_n = 1'b0;
            check_all();
            tick();
        end
        finish_run();
    end
endmodule